// File: doc/BRIEF.md
# Cascaded Voltage-Current Duty Controller

This block runs the per-period control law of a digitally controlled full-bridge inverter. When the period strobe arrives, it latches the sampled inductor current, the sampled load voltage, the three loop gains and the reference phase increment. It also reads a sinusoidal voltage reference from a phase accumulator that drives a quarter-wave sine table. A short fixed pipeline then computes the duty that the modulator will apply during the following switching period.

The law has three terms. The outer proportional voltage loop produces a current demand. The inner proportional current loop acts on the error between that demand and the measured current. The reference is added straight through as a unit-gain feedforward term. The sum is scaled by a saturator gain, nominally one over twice the supply voltage. Half is added to the result, and the duty is clamped to the range zero to one. Sampling and computing take one switching period, so the controller carries the usual one-step delay of a digital loop.

Top module: `cascade_duty_ctrl`

## Requirements
- R1: Reset sets `duty` to 0.5 (code 16384), holds `duty_valid` low and clears the reference phase to zero. The first period after reset therefore uses phase zero.
- R2: `i_meas`, `v_meas`, `gain_inner`, `gain_outer`, `gain_sat` and `phase_step` are sampled only in the cycle where `period_start` is high. Changing them in any other cycle has no effect on the results.
- R3: The reference for a period is 70·sin(2π(j+0.5)/1024). Here j is bits [31:22] of the phase accumulator at the strobe. The accumulator starts at zero and, after each strobe, advances by the sampled `phase_step`, modulo 2^32.
- R4: The unclamped duty is 0.5 + ks·(ref + ki·(ko·(ref − v) − i)). Currents and voltages are signed with 7 fractional bits. `gain_inner` and `gain_outer` are unsigned with 12 fractional bits. `gain_sat` is unsigned with 20 fractional bits. `duty` is unsigned with 15 fractional bits.
- R5: A duty above 1 is output as 32768, and a duty below 0 is output as 0.
- R6: `duty_valid` is a one-cycle pulse on the fifth rising edge counting the edge that samples `period_start`. `duty` takes its new value on that same edge.
- R7: Strobes on consecutive cycles each produce their own result, in order, on consecutive cycles.
- R8: Between results, `duty` holds its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | Start-of-switching-period strobe |
| i_meas | input | 16 | Sampled inductor current, signed, 7 fractional bits |
| v_meas | input | 16 | Sampled load voltage, signed, 7 fractional bits |
| gain_outer | input | 16 | Outer voltage-loop gain, 12 fractional bits |
| gain_inner | input | 16 | Inner current-loop gain, 12 fractional bits |
| gain_sat | input | 16 | Saturator gain, 20 fractional bits |
| phase_step | input | 32 | Reference phase increment per period (f/fs · 2^32) |
| duty | output | 16 | Next-period duty, 15 fractional bits, 0 to 32768 |
| duty_valid | output | 1 | One-cycle pulse when a new duty is presented |

## Verification
The assertions assume that `period_start` is low throughout reset. They also assume that the gain codes stay small enough for the interior products to fit the 32-bit accumulator, which holds for every unsigned 16-bit gain and signed 16-bit sample. The stimulus keeps `period_start` low during both resets and uses gains near the nominal operating point, from 0.5 to 2. The samples cover the full ±80 V and ±10 A range, and extreme values are used only where the clamp is the target. Between strobes, the bench drives the inputs to unrelated values, so any sampling outside the strobe cycle shows up as a wrong result.

// File: rtl/cvc_pkg.sv
package cvc_pkg;

    // Half-sample-offset sine point for a quarter table of `entries` words.
    // Rational sine approximation 16u(1-u)/(5-4u(1-u)) with u = (2k+1)/(4N).
    function automatic longint sine_point(input int idx, input int entries, input longint amp);
        longint d;
        longint a;
        longint prod;
        longint num;
        longint den;
        d    = 4 * longint'(entries);
        a    = 2 * longint'(idx) + 1;
        prod = a * (d - a);
        num  = 16 * prod;
        den  = 5 * d * d - 4 * prod;
        return (amp * num + den / 2) / den;
    endfunction

endpackage

// File: rtl/cvc_ref_gen.sv
module cvc_ref_gen #(
    parameter int PHASE_W  = 32,
    parameter int TBL_BITS = 8,
    parameter int DATA_W   = 16,
    parameter int AMP      = 8960
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic [PHASE_W-1:0]       step,
    output logic signed [DATA_W-1:0] ref_val
);
    import cvc_pkg::*;

    localparam int N = 1 << TBL_BITS;

    typedef struct {
        logic [PHASE_W-1:0]       phase;
        logic signed [DATA_W-1:0] refv;
    } rg_state_t;

    rg_state_t st_q, st_d;

    logic signed [DATA_W-1:0] tbl [N];

    for (genvar g = 0; g < N; g++) begin : g_tbl
        assign tbl[g] = DATA_W'(sine_point(g, N, longint'(AMP)));
    end

    logic [1:0]               quad;
    logic [TBL_BITS-1:0]      idx;
    logic [TBL_BITS-1:0]      addr;
    logic signed [DATA_W-1:0] mag;
    logic signed [DATA_W-1:0] sample;

    always_comb begin
        quad   = st_q.phase[PHASE_W-1 -: 2];
        idx    = st_q.phase[PHASE_W-3 -: TBL_BITS];
        addr   = quad[0] ? ~idx : idx;
        mag    = tbl[addr];
        sample = quad[1] ? -mag : mag;

        st_d = st_q;
        if (strobe) begin
            st_d.refv  = sample;
            st_d.phase = st_q.phase + step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.refv  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_val = st_q.refv;

    a_r3_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_val <= DATA_W'(AMP)) && (ref_val >= -DATA_W'(AMP)));

    a_r3_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> st_q.phase == $past(st_q.phase) + $past(step));

    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(st_q.phase));

endmodule

// File: rtl/cvc_loop_math.sv
module cvc_loop_math #(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 12,
    parameter int ACC_W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic signed [DATA_W-1:0] i_in,
    input  logic signed [DATA_W-1:0] v_in,
    input  logic [GAIN_W-1:0]        k_outer,
    input  logic [GAIN_W-1:0]        k_inner,
    input  logic [GAIN_W-1:0]        k_sat,
    input  logic signed [DATA_W-1:0] ref_in,
    output logic signed [ACC_W-1:0]  ctl_out,
    output logic [GAIN_W-1:0]        ksat_out,
    output logic                     ctl_vld
);
    localparam int P1_W = DATA_W + GAIN_W + 2;
    localparam int P2_W = ACC_W + GAIN_W + 1;

    typedef struct {
        // capture stage
        logic                     a_vld;
        logic signed [DATA_W-1:0] a_i;
        logic signed [DATA_W-1:0] a_v;
        logic [GAIN_W-1:0]        a_kout;
        logic [GAIN_W-1:0]        a_kin;
        logic [GAIN_W-1:0]        a_ksat;
        // voltage error stage
        logic                     b_vld;
        logic signed [DATA_W:0]   b_verr;
        logic signed [DATA_W-1:0] b_i;
        logic signed [DATA_W-1:0] b_ref;
        logic [GAIN_W-1:0]        b_kout;
        logic [GAIN_W-1:0]        b_kin;
        logic [GAIN_W-1:0]        b_ksat;
        // current error stage
        logic                     c_vld;
        logic signed [ACC_W-1:0]  c_cerr;
        logic signed [DATA_W-1:0] c_ref;
        logic [GAIN_W-1:0]        c_kin;
        logic [GAIN_W-1:0]        c_ksat;
        // control sum stage
        logic                     d_vld;
        logic signed [ACC_W-1:0]  d_ctl;
        logic [GAIN_W-1:0]        d_ksat;
    } lm_state_t;

    lm_state_t st_q, st_d;

    logic signed [GAIN_W:0] kout_s;
    logic signed [GAIN_W:0] kin_s;
    logic signed [P1_W-1:0] p_outer;
    logic signed [P2_W-1:0] p_inner;

    always_comb begin
        st_d = st_q;

        // capture
        st_d.a_vld = strobe;
        if (strobe) begin
            st_d.a_i    = i_in;
            st_d.a_v    = v_in;
            st_d.a_kout = k_outer;
            st_d.a_kin  = k_inner;
            st_d.a_ksat = k_sat;
        end

        // voltage error against the reference latched on the same strobe
        st_d.b_vld  = st_q.a_vld;
        st_d.b_verr = (DATA_W+1)'(ref_in) - (DATA_W+1)'(st_q.a_v);
        st_d.b_i    = st_q.a_i;
        st_d.b_ref  = ref_in;
        st_d.b_kout = st_q.a_kout;
        st_d.b_kin  = st_q.a_kin;
        st_d.b_ksat = st_q.a_ksat;

        // outer loop output minus measured current
        kout_s      = {1'b0, st_q.b_kout};
        p_outer     = st_q.b_verr * kout_s;
        st_d.c_vld  = st_q.b_vld;
        st_d.c_cerr = ACC_W'(p_outer >>> GAIN_FRAC) - ACC_W'(st_q.b_i);
        st_d.c_ref  = st_q.b_ref;
        st_d.c_kin  = st_q.b_kin;
        st_d.c_ksat = st_q.b_ksat;

        // inner loop plus unit feedforward
        kin_s       = {1'b0, st_q.c_kin};
        p_inner     = st_q.c_cerr * kin_s;
        st_d.d_vld  = st_q.c_vld;
        st_d.d_ctl  = ACC_W'(st_q.c_ref) + ACC_W'(p_inner >>> GAIN_FRAC);
        st_d.d_ksat = st_q.c_ksat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.a_vld  <= 1'b0;
            st_q.a_i    <= '0;
            st_q.a_v    <= '0;
            st_q.a_kout <= '0;
            st_q.a_kin  <= '0;
            st_q.a_ksat <= '0;
            st_q.b_vld  <= 1'b0;
            st_q.b_verr <= '0;
            st_q.b_i    <= '0;
            st_q.b_ref  <= '0;
            st_q.b_kout <= '0;
            st_q.b_kin  <= '0;
            st_q.b_ksat <= '0;
            st_q.c_vld  <= 1'b0;
            st_q.c_cerr <= '0;
            st_q.c_ref  <= '0;
            st_q.c_kin  <= '0;
            st_q.c_ksat <= '0;
            st_q.d_vld  <= 1'b0;
            st_q.d_ctl  <= '0;
            st_q.d_ksat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_out  = st_q.d_ctl;
    assign ksat_out = st_q.d_ksat;
    assign ctl_vld  = st_q.d_vld;

    a_r2_gains_held: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(st_q.a_kin) && $stable(st_q.a_kout) && $stable(st_q.a_ksat));

endmodule

// File: rtl/cvc_duty_clamp.sv
module cvc_duty_clamp #(
    parameter int GAIN_W    = 16,
    parameter int ACC_W     = 32,
    parameter int SHIFT     = 12,
    parameter int DUTY_FRAC = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic signed [ACC_W-1:0] ctl,
    input  logic [GAIN_W-1:0]       ksat,
    output logic [DUTY_FRAC:0]      duty,
    output logic                    duty_valid
);
    localparam int DUTY_W = DUTY_FRAC + 1;
    localparam int P_W    = ACC_W + GAIN_W + 1;
    localparam logic signed [ACC_W-1:0] ONE_A  = ACC_W'(1 << DUTY_FRAC);
    localparam logic signed [ACC_W-1:0] HALF_A = ACC_W'(1 << (DUTY_FRAC - 1));

    typedef struct {
        logic [DUTY_W-1:0] duty;
        logic              vld;
    } dc_state_t;

    dc_state_t st_q, st_d;

    logic signed [GAIN_W:0]    ksat_s;
    logic signed [P_W-1:0]     prod;
    logic signed [ACC_W-1:0]   raw;

    always_comb begin
        ksat_s = {1'b0, ksat};
        prod   = ctl * ksat_s;
        raw    = ACC_W'(prod >>> SHIFT) + HALF_A;

        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            if (raw < 0)
                st_d.duty = '0;
            else if (raw > ONE_A)
                st_d.duty = DUTY_W'(ONE_A);
            else
                st_d.duty = DUTY_W'(raw);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.duty <= DUTY_W'(HALF_A);
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty       = st_q.duty;
    assign duty_valid = st_q.vld;

    a_r5_duty_range: assert property (@(posedge clk) disable iff (!rst_n)
        duty <= DUTY_W'(ONE_A));

    a_r8_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_valid |-> $stable(duty));

endmodule

// File: rtl/cascade_duty_ctrl.sv
module cascade_duty_ctrl #(
    parameter int DATA_W    = 16,
    parameter int DATA_FRAC = 7,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 12,
    parameter int SAT_FRAC  = 20,
    parameter int DUTY_FRAC = 15,
    parameter int PHASE_W   = 32,
    parameter int TBL_BITS  = 8,
    parameter int REF_VOLTS = 70,
    parameter int ACC_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 period_start,
    input  logic [DATA_W-1:0]    i_meas,
    input  logic [DATA_W-1:0]    v_meas,
    input  logic [GAIN_W-1:0]    gain_outer,
    input  logic [GAIN_W-1:0]    gain_inner,
    input  logic [GAIN_W-1:0]    gain_sat,
    input  logic [PHASE_W-1:0]   phase_step,
    output logic [DUTY_FRAC:0]   duty,
    output logic                 duty_valid
);
    localparam int AMP   = REF_VOLTS << DATA_FRAC;
    localparam int SHIFT = SAT_FRAC + DATA_FRAC - DUTY_FRAC;
    localparam int LAT   = 5;

    logic signed [DATA_W-1:0] ref_val;
    logic signed [ACC_W-1:0]  ctl;
    logic [GAIN_W-1:0]        ksat_p;
    logic                     ctl_vld;

    cvc_ref_gen #(
        .PHASE_W (PHASE_W),
        .TBL_BITS(TBL_BITS),
        .DATA_W  (DATA_W),
        .AMP     (AMP)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (period_start),
        .step   (phase_step),
        .ref_val(ref_val)
    );

    cvc_loop_math #(
        .DATA_W   (DATA_W),
        .GAIN_W   (GAIN_W),
        .GAIN_FRAC(GAIN_FRAC),
        .ACC_W    (ACC_W)
    ) u_law (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (period_start),
        .i_in    ($signed(i_meas)),
        .v_in    ($signed(v_meas)),
        .k_outer (gain_outer),
        .k_inner (gain_inner),
        .k_sat   (gain_sat),
        .ref_in  (ref_val),
        .ctl_out (ctl),
        .ksat_out(ksat_p),
        .ctl_vld (ctl_vld)
    );

    cvc_duty_clamp #(
        .GAIN_W   (GAIN_W),
        .ACC_W    (ACC_W),
        .SHIFT    (SHIFT),
        .DUTY_FRAC(DUTY_FRAC)
    ) u_clamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (ctl_vld),
        .ctl       (ctl),
        .ksat      (ksat_p),
        .duty      (duty),
        .duty_valid(duty_valid)
    );

    // Checker: strobe history to time the result pulse.
    logic [LAT-1:0] strb_hist_q;
    always_ff @(posedge clk) begin
        if (!rst_n) strb_hist_q <= '0;
        else        strb_hist_q <= {strb_hist_q[LAT-2:0], period_start};
    end

    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid == strb_hist_q[LAT-1]);

endmodule

// File: tb/test_cascade_duty_ctrl.sv
module test_cascade_duty_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        period_start;
    logic [15:0] i_meas, v_meas, gain_outer, gain_inner, gain_sat;
    logic [31:0] phase_step;
    logic [15:0] duty;
    logic        duty_valid;

    always #4 clk = ~clk;

    cascade_duty_ctrl i_cascade_duty_ctrl (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .i_meas(i_meas), .v_meas(v_meas),
        .gain_outer(gain_outer), .gain_inner(gain_inner), .gain_sat(gain_sat),
        .phase_step(phase_step), .duty(duty), .duty_valid(duty_valid)
    );

    typedef struct {
        int    exp;
        int    tol;
        int    due;
        string req;
    } item_t;

    item_t       sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit [31:0]   bphase = '0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic real ref_volts(input bit [31:0] ph);
        int j;
        j = int'(ph[31:22]);
        return 70.0 * $sin(2.0 * 3.14159265358979 * (real'(j) + 0.5) / 1024.0);
    endfunction

    // Push expected duty for a strobe driven at this negedge (R3, R4, R5, R6).
    task automatic push_expect(input int ic, input int vc, input int ko, input int ki,
                               input int ks, input bit [31:0] step, input string req);
        real   r, d;
        item_t it;
        r = ref_volts(bphase);
        bphase = bphase + step;
        d = 0.5 + (real'(ks) / 1048576.0) *
            (r + (real'(ki) / 4096.0) * ((real'(ko) / 4096.0) * (r - real'(vc) / 128.0)
                                         - real'(ic) / 128.0));
        it.tol = 48;
        if (d > 1.02) it.tol = 0;
        if (d < -0.02) it.tol = 0;
        if (d > 1.0) d = 1.0;
        if (d < 0.0) d = 0.0;
        it.exp = int'($floor(d * 32768.0 + 0.5));
        it.due = cyc + 5;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic scramble(input int seed);
        i_meas     = 16'(seed * 40503 + 7);
        v_meas     = 16'(seed * 9973 + 1234);
        gain_outer = 16'(seed * 777 + 99);
        gain_inner = 16'(seed * 313 + 5);
        gain_sat   = 16'(seed * 4099 + 11);
        phase_step = 32'(seed * 32'h9E3779B9);
    endtask

    task automatic drive(input int ic, input int vc, input int ko, input int ki,
                         input int ks, input bit [31:0] step, input string req);
        i_meas       = 16'(ic);
        v_meas       = 16'(vc);
        gain_outer   = 16'(ko);
        gain_inner   = 16'(ki);
        gain_sat     = 16'(ks);
        phase_step   = step;
        period_start = 1'b1;
        push_expect(ic, vc, ko, ki, ks, step, req);
    endtask

    // One period: strobe, then unrelated input values until the next one (R2).
    task automatic period(input int ic, input int vc, input int ko, input int ki,
                          input int ks, input bit [31:0] step, input int gap, input string req);
        @(negedge clk);
        drive(ic, vc, ko, ki, ks, step, req);
        @(negedge clk);
        period_start = 1'b0;
        scramble(ic ^ vc);
        repeat (gap) @(negedge clk);
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && duty_valid && !done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6", "valid without pending strobe", 1, 0);
            end else begin
                item_t it;
                int    diff;
                it = sb.pop_front();
                diff = int'(duty) - it.exp;
                if (diff < 0) diff = -diff;
                check(diff <= it.tol, it.req, "duty", longint'(duty), longint'(it.exp));
                check(cyc == it.due, "R6", "valid cycle", longint'(cyc), longint'(it.due));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        period_start = 1'b0;
        repeat (3) @(negedge clk);
        check(duty == 16'd16384, "R1", "reset duty", longint'(duty), 16384);
        check(duty_valid == 1'b0, "R1", "reset valid", longint'(duty_valid), 0);
        bphase = '0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        period_start = 1'b0;
        scramble(3);
        do_reset();

        // Nominal operation near 50 Hz / 10 kHz, gains 0.9 and 1 (R3, R4, R2).
        for (int n = 0; n < 30; n++) begin
            period(((n * 1237) % 2561) - 1280, ((n * 733) % 20481) - 10240,
                   4096, 3686, 5243, 32'd21474836, 14, "R4");
        end

        // Coarse step sweeping all quadrants, other gains (R3).
        for (int n = 0; n < 26; n++) begin
            period(((n * 911) % 2001) - 1000, ((n * 4111) % 16001) - 8000,
                   8192, 2048, 5243, 32'h0A3D70A4, 10, "R3");
        end

        // Unity gains at the unstable point still compute the law (R4).
        for (int n = 0; n < 6; n++) begin
            period(n * 300 - 900, 2000 - n * 700, 4096, 4096, 5243, 32'h1111_1111, 9, "R4");
        end

        // Clamp at both ends (R5).
        period(0, -25600, 4096, 4096, 5243, 32'd21474836, 9, "R5");
        period(6400, 25600, 4096, 4096, 5243, 32'd21474836, 9, "R5");
        period(-6400, -32000, 8192, 8192, 10486, 32'd0, 9, "R5");

        // Consecutive strobes (R7).
        @(negedge clk);
        drive(100, 500, 4096, 3686, 5243, 32'h0800_0000, "R7");
        @(negedge clk);
        drive(-300, -4000, 4096, 2048, 5243, 32'h0900_0000, "R7");
        @(negedge clk);
        drive(700, 8000, 8192, 3686, 5243, 32'h0A00_0000, "R7");
        @(negedge clk);
        period_start = 1'b0;
        scramble(77);
        repeat (10) @(negedge clk);

        // Hold between results while inputs move (R8, R2).
        begin
            logic [15:0] held;
            bit          ok;
            held = duty;
            ok = 1'b1;
            for (int k = 0; k < 12; k++) begin
                scramble(k + 200);
                @(negedge clk);
                if (duty !== held || duty_valid !== 1'b0) ok = 1'b0;
            end
            check(ok, "R8", "duty held", longint'(duty), longint'(held));
        end

        // Second reset restarts the reference phase at zero (R1).
        do_reset();
        period(200, -1500, 4096, 3686, 5243, 32'd21474836, 10, "R1");
        period(-200, 1500, 4096, 3686, 5243, 32'd21474836, 10, "R1");

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R6", "pending results", longint'(sb.size()), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule